// File: doc/BRIEF.md
# NMI Gate with Pending Latch

This block sits between the sources of non-maskable interrupt requests and a processor core. It applies two kinds of gating to the request it passes on. The first is a mask that software sets and clears through an I/O write. The second is the core's own sequencing: the block blocks delivery from the moment the core acknowledges an interrupt until the core signals an interrupt return.

The mask shares its I/O port with a 7-bit CMOS index register. The top data bit of each write to that port sets the mask, and the lower seven bits are stored as the index. The raw request line is synchronised and is edge-triggered, so a line held high raises only one request. A rising edge that arrives while the block is masked or in service is not lost. It is held as one pending request and is presented once the gating lifts. Several such edges merge into one pending request. The handler that runs for it may therefore find no source still asking for service.

Top module: `nmi_gate`

## Requirements
- R1: After synchronous reset the mask is set (`nmi_masked`=1), and `nmi_req`, `nmi_pending`, `nmi_in_service` and `cmos_index` are all zero.
- R2: A write (`io_wr`=1) to address 0x70 loads the mask from data bit 7: 1 masks and 0 unmasks, taking effect on the next clock edge. A write to any other address leaves the mask and the index unchanged.
- R3: Data bits 6:0 of a write to 0x70 are stored in `cmos_index` on the next clock edge, whatever the value of bit 7. They have no effect on the mask.
- R4: Only a rising transition of `nmi_raw` creates a request. The line passes through two synchroniser flops, so the pending flag is set on the third rising clock edge after the line rises. A line held high creates exactly one request.
- R5: `nmi_req` equals pending and not masked and not in service at every cycle. It therefore stays high until an acknowledge clears it, and it is low whenever the mask is set or the block is in service.
- R6: A rising edge that arrives while the mask is set is held as pending. It is presented on `nmi_req` on the same clock edge that clears the mask.
- R7: An `nmi_ack` pulse while `nmi_req` is high sets in-service and clears pending on the next edge. An `nmi_ack` pulse while `nmi_req` is low changes nothing.
- R8: Only an `nmi_iret` pulse clears in-service. An `nmi_iret` pulse while not in service changes nothing.
- R9: Any number of rising edges during one in-service period leave exactly one pending request. It is presented on `nmi_req` on the edge where `nmi_iret` ends the service period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| nmi_raw | input | 1 | Asynchronous raw NMI request line |
| nmi_ack | input | 1 | Acknowledge pulse from the core |
| nmi_iret | input | 1 | Interrupt-return pulse from the core |
| nmi_req | output | 1 | Registered NMI request to the core |
| cmos_index | output | 7 | Stored CMOS index |
| nmi_masked | output | 1 | Port mask state |
| nmi_in_service | output | 1 | Handler in progress |
| nmi_pending | output | 1 | One request held |

## Verification
The assertions assume that the core sends `nmi_ack` only in response to a visible request and sends `nmi_iret` only once a handler is running. They also assume each strobe lasts a single cycle and that reset is held for at least one edge. The stimulus drives every strobe as a one-cycle pulse between falling edges. It deliberately sends stray acknowledge and return pulses only in the quiet cycles set aside to show they are ignored. It waits for the synchroniser to settle after every change of `nmi_raw`, so that no edge overlaps a strobe.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
  // state held by the sequencer
  typedef struct packed {
    logic pending;
    logic in_svc;
    logic req;
  } nmi_seq_t;

  localparam nmi_seq_t SEQ_RESET = '{pending: 1'b0, in_svc: 1'b0, req: 1'b0};
endpackage

// File: rtl/nmi_edge_sync.sv
module nmi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= raw_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nmi_port_reg.sv
module nmi_port_reg #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0070
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mask_d_o,
  output logic              mask_o,
  output logic [DATA_W-2:0] index_o
);
  localparam int MASK_BIT = DATA_W - 1;
  localparam int IDX_W    = DATA_W - 1;

  logic             hit;
  logic             mask_q;
  logic [IDX_W-1:0] index_q;
  logic [IDX_W-1:0] index_d;

  always_comb begin
    hit      = wr_i && (addr_i == PORT_ADDR[ADDR_W-1:0]);
    mask_d_o = hit ? wdata_i[MASK_BIT]    : mask_q;
    index_d  = hit ? wdata_i[IDX_W-1:0]   : index_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b1;
      index_q <= '0;
    end else begin
      mask_q  <= mask_d_o;
      index_q <= index_d;
    end
  end

  assign mask_o  = mask_q;
  assign index_o = index_q;

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == PORT_ADDR[ADDR_W-1:0]) |=> (mask_q == $past(wdata_i[MASK_BIT])));
  // R2
  other_port_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i != PORT_ADDR[ADDR_W-1:0]) |=> ($stable(mask_q) && $stable(index_q)));
endmodule

// File: rtl/nmi_seq.sv
module nmi_seq
  import nmi_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic mask_d_i,
  input  logic mask_i,
  input  logic ack_i,
  input  logic iret_i,
  output logic req_o,
  output logic pending_o,
  output logic in_svc_o
);
  nmi_seq_t st_q, st_d;
  logic     taken;

  always_comb begin
    st_d  = st_q;
    taken = ack_i && st_q.req;
    if (taken) begin
      st_d.pending = 1'b0;
      st_d.in_svc  = 1'b1;
    end else if (iret_i && st_q.in_svc) begin
      st_d.in_svc  = 1'b0;
    end
    if (rise_i) st_d.pending = 1'b1;
    st_d.req = st_d.pending && !st_d.in_svc && !mask_d_i;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_RESET;
    else     st_q <= st_d;
  end

  assign req_o     = st_q.req;
  assign pending_o = st_q.pending;
  assign in_svc_o  = st_q.in_svc;

  // R5
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    mask_i |-> !req_o);
  // R5
  svc_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    in_svc_o |-> !req_o);
  // R7
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !req_o && !in_svc_o && !iret_i) |=> !in_svc_o);
  // R7
  ack_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_o) |=> in_svc_o);
  // R8
  svc_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_svc_o) |-> $past(iret_i));
  // R8
  stray_iret_chk: assert property (@(posedge clk) disable iff (rst)
    (iret_i && !in_svc_o && !ack_i && !rise_i) |=> ($stable(pending_o) && !in_svc_o));
  // R9
  latch_in_svc_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i && in_svc_o) |=> pending_o);
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] PORT_ADDR   = 16'h0070,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              nmi_raw,
  input  logic              nmi_ack,
  input  logic              nmi_iret,
  output logic              nmi_req,
  output logic [DATA_W-2:0] cmos_index,
  output logic              nmi_masked,
  output logic              nmi_in_service,
  output logic              nmi_pending
);
  logic rise;
  logic mask_d;

  nmi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (nmi_raw),
    .rise_o (rise)
  );

  nmi_port_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (io_wr),
    .addr_i   (io_addr),
    .wdata_i  (io_wdata),
    .mask_d_o (mask_d),
    .mask_o   (nmi_masked),
    .index_o  (cmos_index)
  );

  nmi_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .mask_d_i  (mask_d),
    .mask_i    (nmi_masked),
    .ack_i     (nmi_ack),
    .iret_i    (nmi_iret),
    .req_o     (nmi_req),
    .pending_o (nmi_pending),
    .in_svc_o  (nmi_in_service)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (nmi_masked && !nmi_req && !nmi_pending && !nmi_in_service));
endmodule

// File: tb/nmi_gate_bench.sv
module nmi_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // ops
  localparam logic [2:0] OP_WR = 3'd1, OP_WRX = 3'd2, OP_EDGE = 3'd3,
                         OP_ACK = 3'd4, OP_IRET = 3'd5;
  // {op, data, exp req, exp masked, exp in_service, exp pending}
  localparam logic [14:0] VEC [NV] = '{
    {OP_EDGE, 8'h00, 4'b0101},  // R6 edge while masked held
    {OP_WR,   8'h00, 4'b1001},  // R6 unmask presents it
    {OP_WR,   8'h8F, 4'b0101},  // R2 mask again
    {OP_WR,   8'h05, 4'b1001},  // R2 unmask, nothing lost
    {OP_ACK,  8'h00, 4'b0010},  // R7 take it
    {OP_EDGE, 8'h00, 4'b0011},  // R9 latched in service
    {OP_EDGE, 8'h00, 4'b0011},  // R9 collapses
    {OP_IRET, 8'h00, 4'b1001},  // R9 delivered after return
    {OP_ACK,  8'h00, 4'b0010},  // R7
    {OP_IRET, 8'h00, 4'b0000},  // R8
    {OP_IRET, 8'h00, 4'b0000},  // R8 stray return
    {OP_ACK,  8'h00, 4'b0000},  // R7 stray ack
    {OP_WRX,  8'h80, 4'b0000},  // R2 other port ignored
    {OP_EDGE, 8'h00, 4'b1001}   // R4 plain edge
  };
  localparam string TAG [NV] = '{"R6","R6","R2","R2","R7","R9","R9","R9",
                                 "R7","R8","R8","R7","R2","R4"};

  logic clk = 1'b0, rst = 1'b1;
  logic io_wr = 1'b0, nmi_raw = 1'b0, nmi_ack = 1'b0, nmi_iret = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic nmi_req, nmi_masked, nmi_in_service, nmi_pending;
  logic [6:0] cmos_index;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_gate u_nmi_gate (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .nmi_raw(nmi_raw), .nmi_ack(nmi_ack), .nmi_iret(nmi_iret), .nmi_req(nmi_req),
    .cmos_index(cmos_index), .nmi_masked(nmi_masked),
    .nmi_in_service(nmi_in_service), .nmi_pending(nmi_pending)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic chk4(input string tag, input logic [3:0] exp);
    check(tag, "req/masked/svc/pend",
          {4'b0, nmi_req, nmi_masked, nmi_in_service, nmi_pending}, {4'b0, exp});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    tick(1);
    io_wr = 1'b0;
  endtask

  task automatic pulse_ack;  nmi_ack = 1'b1;  tick(1); nmi_ack = 1'b0;  endtask
  task automatic pulse_iret; nmi_iret = 1'b1; tick(1); nmi_iret = 1'b0; endtask
  task automatic raw_edge;   nmi_raw = 1'b1; tick(3); nmi_raw = 1'b0; tick(3); endtask

  initial begin
    tick(2);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk4("R1", 4'b0100);
    check("R1", "index", {1'b0, cmos_index}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][14:12])
        OP_WR:   wr(16'h0070, VEC[i][11:4]);
        OP_WRX:  wr(16'h0071, VEC[i][11:4]);
        OP_EDGE: raw_edge();
        OP_ACK:  pulse_ack();
        OP_IRET: pulse_iret();
        default: tick(1);
      endcase
      chk4(TAG[i], VEC[i][3:0]);
    end

    // R3 index captured, mask untouched by low bits
    check("R3", "index", {1'b0, cmos_index}, 8'h05);
    pulse_ack();
    pulse_iret();
    wr(16'h0070, 8'h7F);
    check("R3", "index", {1'b0, cmos_index}, 8'h7F);
    chk4("R3", 4'b0000);
    wr(16'h0070, 8'hAA);
    check("R3", "index", {1'b0, cmos_index}, 8'h2A);
    chk4("R2", 4'b0100);
    wr(16'h0070, 8'h00);

    // R4 timing: pending on third edge, not before
    nmi_raw = 1'b1;
    tick(2);
    chk4("R4", 4'b0000);
    tick(1);
    chk4("R4", 4'b1001);
    // R5 request holds until acknowledged while line stays high
    tick(10);
    chk4("R5", 4'b1001);
    pulse_ack();
    tick(10);
    chk4("R4", 4'b0010);   // held high: no new request
    nmi_raw = 1'b0;
    tick(3);
    pulse_iret();
    chk4("R8", 4'b0000);

    // R5 mask set while a request is up drops it on the same edge
    raw_edge();
    chk4("R5", 4'b1001);
    wr(16'h0070, 8'h80);
    chk4("R5", 4'b0101);

    // R1 reset mid-state
    rst = 1'b1; tick(1); rst = 1'b0;
    chk4("R1", 4'b0100);
    check("R1", "index", {1'b0, cmos_index}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule